// File: doc/BRIEF.md
# Six-Stage Pipeline Flow Controller

This block follows instructions through a six-stage in-order pipeline: fetch, decode, operand-address calculation, operand fetch, execute and write-back. Each stage is modelled only as an occupancy bit and an instruction tag. No operands, results or memory contents are held here. A front end presents a tag each cycle at the address the block drives on `fetch_pc`. The block then moves every occupied stage one step toward write-back. An instruction that reaches write-back is reported as retired.

Two events disturb the flow. A branch resolved as taken in execute discards everything younger than it. Fetch is then steered to the branch target, and the target is fetched in the very next cycle. A stall request freezes the four front stages and feeds a bubble into execute. Execute and write-back keep draining while the stall lasts.

Top module: `pfc_top`

## Requirements
- R1: While `rst_n` is low, every bit of `stage_vld` is 0 and `fetch_pc` equals `reset_vec`.
- R2: With no stall and no taken branch, each stage takes the previous stage's valid bit and tag at the next clock edge. The fetch stage takes `fetch_vld`/`fetch_tag`. In `stage_vld`, bit 0 is fetch, bit 1 decode, bit 2 operand-address, bit 3 operand fetch, bit 4 execute and bit 5 write-back. The tag of stage i is `stage_tag[i*TAG_W +: TAG_W]`.
- R3: For n requests accepted on consecutive edges, counting the first acceptance edge as edge 1, the last instruction retires after edge 6 + (n − 1).
- R4: `retire_vld` is the write-back valid bit and `retire_tag` is the write-back tag.
- R5: When `br_taken` is high and execute is valid, stages fetch through execute are invalid after the next edge. The branch itself moves to write-back. The discarded instructions never raise `retire_vld`.
- R6: After a taken branch, `fetch_pc` equals `br_target` at the next edge. An instruction fetched there retires six edges after it is accepted.
- R7: `br_taken` has no effect while execute is invalid.
- R8: While `stall` is high and no branch is taken, fetch through operand fetch hold their contents. Execute becomes invalid, and write-back takes the previous execute contents.
- R9: `fetch_pc` advances by `PC_STEP` at each edge with no stall and no taken branch. It holds its value while stalled.
- R10: A taken branch takes priority over `stall` in the same cycle.
- R11: `fetch_take` is high exactly when neither a stall nor a taken branch is present. Only then is the fetch request captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reset_vec | input | ADDR_W | Fetch address loaded during reset |
| fetch_vld | input | 1 | A fetch request is presented at `fetch_pc` |
| fetch_tag | input | TAG_W | Tag of the presented instruction |
| stall | input | 1 | Freeze the front four stages |
| br_taken | input | 1 | The instruction in execute is a taken branch |
| br_target | input | ADDR_W | Address to fetch after a taken branch |
| fetch_take | output | 1 | The fetch request is captured this cycle |
| fetch_pc | output | ADDR_W | Address of the instruction to fetch this cycle |
| stage_vld | output | 6 | Occupancy per stage, bit 0 is fetch |
| stage_tag | output | 6*TAG_W | Tag per stage, field i is stage i |
| retire_vld | output | 1 | An instruction retires this cycle |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
Several behaviours are checked by assertions on every cycle: the one-step shift of occupancy, the front freeze with its execute bubble, the clearing on a taken branch, the address redirect and increment, and the capture of the request when `fetch_take` is high. Some behaviours only the directed scenarios can show. These are the end-to-end retire latency of a stream, the tags arriving in order, and the fact that discarded instructions never retire. The same holds for the ignored branch on an empty execute stage, stall release and the branch-over-stall priority, all seen through the port values over many cycles.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NUM_ST = 6;
  localparam int ST_FI  = 0;
  localparam int ST_DI  = 1;
  localparam int ST_CO  = 2;
  localparam int ST_FO  = 3;
  localparam int ST_EX  = 4;
  localparam int ST_WB  = 5;
endpackage

// File: rtl/pfc_stage_reg.sv
module pfc_stage_reg #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             d_vld,
  input  logic [TAG_W-1:0] d_tag,
  output logic             q_vld,
  output logic [TAG_W-1:0] q_tag
);
  logic             vld_nxt;
  logic [TAG_W-1:0] tag_nxt;

  always_comb begin
    vld_nxt = q_vld;
    tag_nxt = q_tag;
    if (en) begin
      vld_nxt = d_vld & ~clr;
      tag_nxt = d_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_tag <= '0;
    end else begin
      q_vld <= vld_nxt;
      q_tag <= tag_nxt;
    end
  end

  p_clr_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> !q_vld);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_vld) && $stable(q_tag)));
endmodule

// File: rtl/pfc_flow_ctrl.sv
module pfc_flow_ctrl
  import pfc_pkg::*;
(
  input  logic              stall,
  input  logic              br_taken,
  input  logic              ex_vld,
  output logic              flush,
  output logic              fetch_take,
  output logic [NUM_ST-1:0] st_en,
  output logic [NUM_ST-1:0] st_clr
);
  assign flush      = br_taken & ex_vld;
  assign fetch_take = ~stall & ~flush;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    if (i < ST_EX) begin : g_front
      assign st_en[i]  = flush | ~stall;
      assign st_clr[i] = flush;
    end else if (i == ST_EX) begin : g_ex
      assign st_en[i]  = 1'b1;
      assign st_clr[i] = flush | stall;
    end else begin : g_back
      assign st_en[i]  = 1'b1;
      assign st_clr[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pfc_fetch_pc.sv
module pfc_fetch_pc #(
  parameter int ADDR_W  = 16,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reset_vec,
  input  logic              stall,
  input  logic              flush,
  input  logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);
  logic [ADDR_W-1:0] pc_nxt;

  always_comb begin
    if (flush)       pc_nxt = br_target;
    else if (!stall) pc_nxt = pc + STEP;
    else             pc_nxt = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= reset_vec;
    else        pc <= pc_nxt;
  end

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pc == $past(br_target)));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall) |=> (pc == $past(pc) + STEP));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && stall) |=> $stable(pc));
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int PC_STEP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reset_vec,
  input  logic                    fetch_vld,
  input  logic [TAG_W-1:0]        fetch_tag,
  input  logic                    stall,
  input  logic                    br_taken,
  input  logic [ADDR_W-1:0]       br_target,
  output logic                    fetch_take,
  output logic [ADDR_W-1:0]       fetch_pc,
  output logic [NUM_ST-1:0]       stage_vld,
  output logic [NUM_ST*TAG_W-1:0] stage_tag,
  output logic                    retire_vld,
  output logic [TAG_W-1:0]        retire_tag
);
  logic              flush;
  logic [NUM_ST-1:0] st_en;
  logic [NUM_ST-1:0] st_clr;
  logic [NUM_ST-1:0] d_vld;
  logic [NUM_ST*TAG_W-1:0] d_tag;

  pfc_flow_ctrl u_ctrl (
    .stall      (stall),
    .br_taken   (br_taken),
    .ex_vld     (stage_vld[ST_EX]),
    .flush      (flush),
    .fetch_take (fetch_take),
    .st_en      (st_en),
    .st_clr     (st_clr)
  );

  assign d_vld[ST_FI]              = fetch_vld;
  assign d_tag[ST_FI*TAG_W +: TAG_W] = fetch_tag;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign d_vld[i]              = stage_vld[i-1];
      assign d_tag[i*TAG_W +: TAG_W] = stage_tag[(i-1)*TAG_W +: TAG_W];
    end
    pfc_stage_reg #(.TAG_W(TAG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (st_en[i]),
      .clr   (st_clr[i]),
      .d_vld (d_vld[i]),
      .d_tag (d_tag[i*TAG_W +: TAG_W]),
      .q_vld (stage_vld[i]),
      .q_tag (stage_tag[i*TAG_W +: TAG_W])
    );
  end

  pfc_fetch_pc #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_vec (reset_vec),
    .stall     (stall),
    .flush     (flush),
    .br_target (br_target),
    .pc        (fetch_pc)
  );

  assign retire_vld = stage_vld[ST_WB];
  assign retire_tag = stage_tag[ST_WB*TAG_W +: TAG_W];

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flush) |=> (stage_vld[NUM_ST-1:1] == $past(stage_vld[NUM_ST-2:0])));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && stage_vld[ST_EX]) |=> ((stage_vld[ST_EX:0] == '0) && stage_vld[ST_WB]));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ((stage_vld[ST_FO:0] == $past(stage_vld[ST_FO:0]))
                            && !stage_vld[ST_EX]
                            && (stage_vld[ST_WB] == $past(stage_vld[ST_EX]))));
  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |=> (stage_vld[ST_FI] == $past(fetch_vld)));
  p_no_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_vld[ST_EX] && !stall) |=> (fetch_pc == $past(fetch_pc) + ADDR_W'(PC_STEP)));
endmodule

// File: tb/pfc_top_bench.sv
`timescale 1ns/1ps
module pfc_top_bench;
  localparam int TAG_W = 8;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_vld, stall, br_taken;
  logic [TAG_W-1:0] fetch_tag;
  logic [ADDR_W-1:0] br_target;
  logic fetch_take;
  logic [ADDR_W-1:0] fetch_pc;
  logic [5:0] stage_vld;
  logic [6*TAG_W-1:0] stage_tag;
  logic retire_vld;
  logic [TAG_W-1:0] retire_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfc_top #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .PC_STEP(4)) u_pfc_top (
    .clk(clk), .rst_n(rst_n), .reset_vec(RV), .fetch_vld(fetch_vld),
    .fetch_tag(fetch_tag), .stall(stall), .br_taken(br_taken),
    .br_target(br_target), .fetch_take(fetch_take), .fetch_pc(fetch_pc),
    .stage_vld(stage_vld), .stage_tag(stage_tag), .retire_vld(retire_vld),
    .retire_tag(retire_tag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] tg(int i);
    return stage_tag[i*TAG_W +: TAG_W];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic v, logic [TAG_W-1:0] t, logic s, logic b, logic [ADDR_W-1:0] a);
    fetch_vld = v; fetch_tag = t; stall = s; br_taken = b; br_target = a;
  endtask

  task automatic t_reset();
    drive(0, 0, 0, 0, 0);
    rst_n = 0;
    repeat (3) step();
    chk("R1 vld", {26'd0, stage_vld}, 0);
    chk("R1 pc", {16'd0, fetch_pc}, {16'd0, RV});
    rst_n = 1;
  endtask

  task automatic t_stream();
    t_reset();
    for (int s = 1; s <= 14; s++) begin
      if (s <= 8) drive(1, TAG_W'(s), 0, 0, 0); else drive(0, 0, 0, 0, 0);
      step();
      if (s == 3) begin
        chk("R2 occupancy", {26'd0, stage_vld}, 32'h07);
        chk("R2 tags", {8'd0, tg(2), tg(1), tg(0)}, 32'h010203);
      end
      if (s >= 6 && s <= 13) begin
        chk("R4 retire", {31'd0, retire_vld}, 1);
        chk("R3 order", {24'd0, retire_tag}, s - 5);
      end
      if (s == 14) chk("R3 last at 6+(n-1)", {31'd0, retire_vld}, 0);
      if (s == 8) chk("R9 pc step", {16'd0, fetch_pc}, {16'd0, RV + 16'd32});
    end
  endtask

  task automatic t_branch();
    t_reset();
    for (int s = 1; s <= 5; s++) begin drive(1, TAG_W'(s), 0, 0, 0); step(); end
    drive(1, 8'h06, 0, 1, 16'h0400);
    #0.1;
    chk("R11 take low on branch", {31'd0, fetch_take}, 0);
    step();
    chk("R5 cleared", {26'd0, stage_vld}, 32'h20);
    chk("R5 branch retires", {24'd0, retire_tag}, 1);
    chk("R6 redirect", {16'd0, fetch_pc}, 32'h0400);
    drive(1, 8'h21, 0, 0, 0);
    for (int s = 7; s <= 12; s++) begin
      step();
      drive(0, 0, 0, 0, 0);
      if (s < 12) chk("R5 discarded never retire", {31'd0, retire_vld}, 0);
      else begin
        chk("R6 target retire", {31'd0, retire_vld}, 1);
        chk("R6 target tag", {24'd0, retire_tag}, 32'h21);
      end
    end
  endtask

  task automatic t_br_ignored();
    t_reset();
    drive(1, 8'h33, 0, 1, 16'h0500);
    step();
    chk("R7 pc unaffected", {16'd0, fetch_pc}, {16'd0, RV + 16'd4});
    chk("R7 fetch kept", {26'd0, stage_vld}, 32'h01);
    chk("R7 tag", {24'd0, tg(0)}, 32'h33);
  endtask

  task automatic t_stall();
    t_reset();
    for (int s = 1; s <= 5; s++) begin drive(1, TAG_W'(s), 0, 0, 0); step(); end
    drive(1, 8'h66, 1, 0, 0);
    #0.1;
    chk("R11 take low on stall", {31'd0, fetch_take}, 0);
    step();
    chk("R8 freeze+bubble", {26'd0, stage_vld}, 32'h2F);
    chk("R8 front tags", {tg(3), tg(2), tg(1), tg(0)}, 32'h02030405);
    chk("R8 wb drains", {24'd0, retire_tag}, 1);
    step();
    chk("R8 second cycle", {26'd0, stage_vld}, 32'h0F);
    chk("R9 pc held", {16'd0, fetch_pc}, {16'd0, RV + 16'd20});
    drive(0, 0, 0, 0, 0);
    step();
    chk("R8 release", {26'd0, stage_vld}, 32'h1E);
    chk("R8 release tags", {tg(4), tg(3), tg(2), tg(1)}, 32'h02030405);
    chk("R9 pc resumes", {16'd0, fetch_pc}, {16'd0, RV + 16'd24});
    step();
    chk("R4 after stall", {23'd0, retire_vld, retire_tag}, 32'h102);
  endtask

  task automatic t_priority();
    t_reset();
    for (int s = 1; s <= 5; s++) begin drive(1, TAG_W'(s), 0, 0, 0); step(); end
    drive(1, 8'h77, 1, 1, 16'h0700);
    step();
    chk("R10 flush wins", {26'd0, stage_vld}, 32'h20);
    chk("R10 pc", {16'd0, fetch_pc}, 32'h0700);
    drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0;
    drive(0, 0, 0, 0, 0);
    t_stream();
    t_branch();
    t_br_ignored();
    t_stall();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule